// File: doc/BRIEF.md
# Toggle-Handshake Word Crossing

This block carries one data word at a time from a source clock domain into an unrelated destination clock domain. The word itself never passes through a synchronizer. The source side loads the word into a holding register and flips a single request bit. Only that bit crosses through a flop chain. When the destination sees the flipped request, it copies the whole held word into its output register in one cycle and raises a one-cycle valid pulse.

The destination echoes the request state back as an acknowledge bit, which is synchronized into the source domain. Until that acknowledge matches the request, the source reports busy. While it is busy, the holding register stays frozen and further send requests are dropped. A fast source therefore cannot overwrite a word that a slow destination has not yet taken. Logic on the source side offers a word by raising `src_send` for one cycle while `src_busy` is low.

Top module: `word_handoff`

## Requirements
- R1: After reset, `src_busy` is 0, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A source clock edge that samples `src_send` high while `src_busy` is low accepts the word on `src_data`, and `src_busy` is 1 from the next source cycle on.
- R3: A source clock edge that samples `src_send` high while `src_busy` is high has no effect: no extra word is ever delivered and the pending word is unchanged.
- R4: Every accepted word appears on `dst_data` exactly once, in the order it was accepted. `dst_valid` is high for exactly one destination cycle per word, the cycle in which the new word is first shown.
- R5: `dst_data` changes only in a cycle where `dst_valid` is high, and all of its bits change together. Between deliveries it holds its last value.
- R6: `src_busy` stays high until the destination has taken the word and its acknowledge has come back. No word is lost, whichever of the two clocks is faster.
- R7: The source holding register does not change while `src_busy` is high.
- R8: The request passes through a chain of `SYNC_STAGES` (at least 2) destination flops with no logic in front of the first one. `dst_valid` therefore rises no sooner than `SYNC_STAGES` destination edges after the accepting source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, synchronous |
| src_data | input | WIDTH | Word offered by the source |
| src_send | input | 1 | Request to send `src_data` |
| src_busy | output | 1 | A word is in flight; sends are ignored |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, synchronous |
| dst_data | output | WIDTH | Last word delivered |
| dst_valid | output | 1 | One-cycle pulse marking a new `dst_data` |

## Verification
The bench sends every 8-bit value twice: once with a source clock much faster than the destination clock, and once with a destination clock faster than the source clock. Between real sends it hammers `src_send` with a scrambled value while busy. A design that accepted those sends would deliver an unexpected word, or would corrupt the pending one by changing the held register mid-crossing. A design that dropped busy early would lose words under the fast-source ratio, and the delivered count would fall short. A design that let the output drift between pulses, or repeated a pulse, would trip the per-cycle output monitor. A design that bypassed the flop chain would show a delivery latency shorter than the chain depth.

// File: rtl/word_handoff_pkg.sv
// Package: shared defaults for the word crossing block.
// Assumes: nothing; holds constants only.
package word_handoff_pkg;
    localparam int unsigned DEF_WIDTH  = 8;
    localparam int unsigned DEF_STAGES = 2;
    localparam int unsigned MIN_STAGES = 2;
endpackage

// File: rtl/handoff_sync_chain.sv
// handoff_sync_chain: single-bit flop chain into the clock domain of clk.
// Assumes: d_in comes straight from a flop in another domain with no logic
// in front of stage 0; STAGES is clamped to at least the package minimum.
module handoff_sync_chain
    import word_handoff_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int unsigned DEPTH = (STAGES < MIN_STAGES) ? MIN_STAGES : STAGES;

    logic [DEPTH-1:0] chain_q;

    // Stage 0 samples the foreign bit directly.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_in;
    end

    // Remaining stages shift the bit along to let it settle.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign q_out = chain_q[DEPTH-1];
endmodule

// File: rtl/handoff_src_ctrl.sv
// handoff_src_ctrl: source side. Captures a word on an accepted send,
// flips the request toggle and stays busy until the acknowledge matches.
// Assumes: ack_sync is already synchronized into src_clk.
module handoff_src_ctrl
    import word_handoff_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             send,
    input  logic             ack_sync,
    output logic             busy,
    output logic             req_tgl,
    output logic [WIDTH-1:0] hold_q
);
    logic accept;

    // A send counts only when nothing is in flight.
    assign busy   = req_tgl ^ ack_sync;
    assign accept = send & ~busy;

    // Request toggle flips once per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_tgl <= 1'b0;
        else if (accept) req_tgl <= ~req_tgl;
    end

    // Holding register loads on accept and is frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (accept) hold_q <= data_in;
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !busy) |=> busy);
    // R3
    ignore_busy_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && busy) |=> $stable(req_tgl));
    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_q));
endmodule

// File: rtl/handoff_dst_ctrl.sv
// handoff_dst_ctrl: destination side. Detects a change of the synchronized
// request, loads the whole held word at once and pulses valid.
// Assumes: src_word was stable for the whole synchronization time.
module handoff_dst_ctrl
    import word_handoff_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic [WIDTH-1:0] src_word,
    output logic             ack_tgl,
    output logic [WIDTH-1:0] word_q,
    output logic             valid_q
);
    logic load;

    // A new word is present when the synchronized request differs from the last seen.
    assign load = req_sync ^ ack_tgl;

    // Remember the request state; it doubles as the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    ack_tgl <= 1'b0;
        else if (load) ack_tgl <= req_sync;
    end

    // Whole-word capture from the held source register.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= src_word;
    end

    // Valid mirrors the load for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= load;
    end

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(word_q));
endmodule

// File: rtl/word_handoff.sv
// word_handoff: top. Source control, destination control and the two
// toggle synchronizers (request forward, acknowledge back).
// Assumes: the two clocks are unrelated; each reset is synchronous to its clock.
module word_handoff
    import word_handoff_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = DEF_STAGES
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic [WIDTH-1:0] src_data,
    input  logic             src_send,
    output logic             src_busy,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_data,
    output logic             dst_valid
);
    logic             req_tgl;
    logic             req_sync;
    logic             ack_tgl;
    logic             ack_sync;
    logic [WIDTH-1:0] hold_q;

    handoff_src_ctrl #(.WIDTH(WIDTH)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .data_in  (src_data),
        .send     (src_send),
        .ack_sync (ack_sync),
        .busy     (src_busy),
        .req_tgl  (req_tgl),
        .hold_q   (hold_q)
    );

    handoff_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_in  (req_tgl),
        .q_out (req_sync)
    );

    handoff_dst_ctrl #(.WIDTH(WIDTH)) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_sync (req_sync),
        .src_word (hold_q),
        .ack_tgl  (ack_tgl),
        .word_q   (dst_data),
        .valid_q  (dst_valid)
    );

    handoff_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d_in  (ack_tgl),
        .q_out (ack_sync)
    );
endmodule

// File: tb/word_handoff_bench.sv
// word_handoff_bench: sends every 8-bit value under two clock ratios,
// with ignored sends while busy, and checks delivery order, count and latency.
module word_handoff_bench;
    localparam int    SRC_PERIOD = 10;
    localparam int    W          = 8;
    localparam int    STG        = 2;
    localparam int    NWORDS     = 1 << W;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_send = 1'b0;
    logic         src_busy;
    logic [W-1:0] dst_data;
    logic         dst_valid;

    int dst_half = 17;
    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_q [0:2*NWORDS-1];
    int accept_edge [0:2*NWORDS-1];
    int n_sent = 0;
    int n_got = 0;
    int dst_edges = 0;
    logic [W-1:0] last_out = '0;
    logic mon_on = 1'b0;

    always #(SRC_PERIOD/2) src_clk = ~src_clk;
    always #(dst_half)     dst_clk = ~dst_clk;
    always @(posedge dst_clk) dst_edges++;

    word_handoff #(.WIDTH(W), .SYNC_STAGES(STG)) u_word_handoff (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_data(src_data),
        .src_send(src_send), .src_busy(src_busy),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_data(dst_data), .dst_valid(dst_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Destination monitor: order, latency, single pulse and output hold.
    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (dst_valid) begin
                if (n_got < n_sent) begin
                    // R4 in-order exact word
                    check(dst_data == exp_q[n_got], "R4", dst_data, exp_q[n_got]);
                    // R8 latency through the chain
                    check(dst_edges - accept_edge[n_got] >= STG, "R8",
                          dst_edges - accept_edge[n_got], STG);
                end else begin
                    // R3 nothing beyond the accepted words
                    check(1'b0, "R3", n_got + 1, n_sent);
                end
                n_got++;
            end else begin
                // R5 output holds between deliveries
                check(dst_data == last_out, "R5", dst_data, last_out);
            end
            last_out = dst_data;
        end
    end

    task automatic push(input logic [W-1:0] v);
        @(negedge src_clk);
        while (src_busy) begin
            src_send = 1'b1;
            src_data = v ^ 8'h5A;
            @(negedge src_clk);
        end
        src_send = 1'b1;
        src_data = v;
        exp_q[n_sent] = v;
        @(posedge src_clk);
        accept_edge[n_sent] = dst_edges;
        n_sent++;
        @(negedge src_clk);
        src_send = 1'b0;
        src_data = ~v;
        // R2 busy right after accept
        check(src_busy == 1'b1, "R2", src_busy, 1);
    endtask

    task automatic drain;
        int guard = 0;
        while ((src_busy || n_got < n_sent) && guard < 2000) begin
            @(negedge src_clk);
            guard++;
        end
        repeat (20) @(negedge dst_clk);
        // R6 no word lost
        check(n_got == n_sent, "R6", n_got, n_sent);
        check(src_busy == 1'b0, "R6", src_busy, 0);
    endtask

    initial begin
        repeat (4) @(negedge src_clk);
        repeat (4) @(negedge dst_clk);
        // R1 reset state
        check(src_busy == 1'b0, "R1", src_busy, 0);
        check(dst_valid == 1'b0, "R1", dst_valid, 0);
        check(dst_data == '0, "R1", dst_data, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        mon_on = 1'b1;
        // Phase A: fast source, slow destination
        for (int v = 0; v < NWORDS; v++) push(v[W-1:0]);
        drain();
        // Phase B: slow source, fast destination
        dst_half = 3;
        repeat (10) @(negedge dst_clk);
        for (int v = NWORDS - 1; v >= 0; v--) push(v[W-1:0]);
        drain();
        // R3 a send while busy leaves the pending word unchanged
        check(dst_data == 8'h00, "R3", dst_data, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(SRC_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule